// File: doc/BRIEF.md
# Byte-Lane Copy and Hold Buffer

This block sits on a 32-bit system data bus that is split into four byte lanes. It is used in transfers where the two sides have different bus widths. Each lane has a holding register that loads the lane's byte on a clock edge when that lane's capture strobe is low.

From the held bytes, a fixed copy network can move a byte across any of four lane pairs: 0-1, 0-2, 0-3 and 1-3. One shared direction input chooses whether copies go upward (from the lower lane to the higher lane) or downward. The result is presented on a 32-bit data output. A 4-bit per-lane drive indication models the tri-state bus drivers. Three active-low drive strobes control those drivers. A test input, when low, turns all driving off.

Cycle decoding and the generation of the strobes are done by a neighbouring controller.

Top module: `lane_swap_buf`

## Requirements
- R1: Lane n occupies bits 8n+7 down to 8n of `bus_in` and `data_out`: lane 0 is bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16 and lane 3 is bits 31:24.
- R2: Driving `rst_n` low clears every holding register to zero at once, without waiting for a clock edge.
- R3: At a rising edge of `clk`, a lane whose `cap_en_n` bit is low loads its byte from `bus_in`. A lane whose bit is high keeps its held value.
- R4: A lane that no active copy targets outputs its own held byte.
- R5: `copy_en_n` bit 0 selects pair 0-1, bit 1 selects pair 0-2, bit 2 selects pair 0-3 and bit 3 selects pair 1-3. Each bit is active low. With `copy_up` high, each active pair puts the held byte of its lower lane onto its higher lane.
- R6: With `copy_up` low, each active pair puts the held byte of its higher lane onto its lower lane.
- R7: When several active pairs target the same lane, the pair with the lowest `copy_en_n` bit index wins.
- R8: Copies always read held bytes, never the result of another copy. For example, a downward copy on pairs 0-1 and 1-3 gives lane 0 the held lane 1 byte and gives lane 1 the held lane 3 byte.
- R9: `lane_drive` is active high and shows which lanes are driven. `drv_en_n` bit 0 drives lane 0, bit 1 drives lane 1, and bit 2 drives lanes 2 and 3 together. Each bit is active low.
- R10: While `test_n` is low, `lane_drive` is all zero and `data_out` is zero, whatever the other controls are.
- R11: A lane that is not driven shows zero on `data_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 32 | Bus data sampled by the capture strobes |
| cap_en_n | input | 4 | Per-lane capture strobes, active low |
| copy_en_n | input | 4 | Per-pair copy strobes, active low |
| copy_up | input | 1 | Copy direction: 1 copies from the lower lane to the higher lane, 0 copies from the higher lane to the lower lane |
| drv_en_n | input | 3 | Drive strobes, active low: lane 0, lane 1, lanes 2 and 3 |
| test_n | input | 1 | Low forces all driving off |
| data_out | output | 32 | Steered bytes; zero on lanes that are not driven |
| lane_drive | output | 4 | Per-lane drive indication, active high |

## Verification
Some properties are checked by assertions on every cycle:
- lanes 2 and 3 are always driven together;
- the test input silences every lane;
- a lane that is not driven reads zero;
- a lane with a capture strobe low holds the sampled byte after the edge, and every other lane keeps its value;
- with no copies active, the output equals the held bytes.

The remaining behaviour is shown only by the bench scenarios. This covers which byte each lane pair carries in each direction and how priority is resolved when several copies target the same lane. It also covers the rule that copies read held bytes and not chained results, and the immediate clear on an asynchronous reset. The bench shows these through a sweep of all strobe and direction combinations against an arithmetic model.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int PAIRS  = 4;
  localparam int OE_N   = 3;
  localparam int BUS_W  = BYTE_W * LANES;

  typedef logic [LANES-1:0][BYTE_W-1:0] lane_vec_t;

  // Lower lane of copy pair p: 0-1, 0-2, 0-3, 1-3
  function automatic int pair_lo(input int p);
    return (p == 3) ? 1 : 0;
  endfunction

  // Higher lane of copy pair p
  function automatic int pair_hi(input int p);
    return (p == 3) ? 3 : p + 1;
  endfunction

  // Drive strobe index serving lane l (lanes 2 and 3 share one)
  function automatic int lane_grp(input int l);
    return (l < OE_N - 1) ? l : OE_N - 1;
  endfunction
endpackage

// File: rtl/lsb_hold_regs.sv
module lsb_hold_regs
  import lsb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_in,
  input  logic [LANES-1:0] cap_en_n,
  output lane_vec_t        hold_q
);
  lane_vec_t hold_d;

  always_comb begin
    hold_d = hold_q;
    for (int l = 0; l < LANES; l++) begin
      if (!cap_en_n[l]) hold_d[l] = bus_in[l*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end
endmodule

// File: rtl/lsb_copy_net.sv
module lsb_copy_net
  import lsb_pkg::*;
(
  input  lane_vec_t        hold_q,
  input  logic [PAIRS-1:0] copy_en_n,
  input  logic             copy_up,
  output lane_vec_t        lane_val
);
  for (genvar d = 0; d < LANES; d++) begin : g_dst
    always_comb begin
      lane_val[d] = hold_q[d];
      // Walk from the highest pair index down so the lowest index wins
      for (int p = PAIRS - 1; p >= 0; p--) begin
        if (!copy_en_n[p]) begin
          if (copy_up && pair_hi(p) == d)       lane_val[d] = hold_q[pair_lo(p)];
          else if (!copy_up && pair_lo(p) == d) lane_val[d] = hold_q[pair_hi(p)];
        end
      end
    end
  end
endmodule

// File: rtl/lsb_drive_ctl.sv
module lsb_drive_ctl
  import lsb_pkg::*;
(
  input  logic [OE_N-1:0]  drv_en_n,
  input  logic             test_n,
  output logic [LANES-1:0] lane_drive
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_drive[l] = test_n & ~drv_en_n[lane_grp(l)];
  end
endmodule

// File: rtl/lane_swap_buf.sv
module lane_swap_buf
  import lsb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_in,
  input  logic [LANES-1:0] cap_en_n,
  input  logic [PAIRS-1:0] copy_en_n,
  input  logic             copy_up,
  input  logic [OE_N-1:0]  drv_en_n,
  input  logic             test_n,
  output logic [BUS_W-1:0] data_out,
  output logic [LANES-1:0] lane_drive
);
  lane_vec_t hold_q;
  lane_vec_t lane_val;

  lsb_hold_regs u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_in   (bus_in),
    .cap_en_n (cap_en_n),
    .hold_q   (hold_q)
  );

  lsb_copy_net u_copy (
    .hold_q    (hold_q),
    .copy_en_n (copy_en_n),
    .copy_up   (copy_up),
    .lane_val  (lane_val)
  );

  lsb_drive_ctl u_drv (
    .drv_en_n   (drv_en_n),
    .test_n     (test_n),
    .lane_drive (lane_drive)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign data_out[l*BYTE_W +: BYTE_W] = lane_drive[l] ? lane_val[l] : '0;
  end
endmodule

// File: rtl/lsb_chk.sv
module lsb_chk
  import lsb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] bus_in,
  input logic [LANES-1:0] cap_en_n,
  input logic [PAIRS-1:0] copy_en_n,
  input logic [OE_N-1:0]  drv_en_n,
  input logic             test_n,
  input logic [BUS_W-1:0] data_out,
  input logic [LANES-1:0] lane_drive,
  input logic [BUS_W-1:0] hold_flat
);
  // R9
  shared_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_drive[2] == lane_drive[3]);

  // R10
  test_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_n |-> (lane_drive == '0 && data_out == '0));

  // R4
  plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_n && (&copy_en_n) && drv_en_n == '0) |-> data_out == hold_flat);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_drive[l] |-> data_out[l*BYTE_W +: BYTE_W] == '0);

    // R3
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en_n[l] |=> hold_flat[l*BYTE_W +: BYTE_W] == $past(bus_in[l*BYTE_W +: BYTE_W]));

    // R3
    cap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en_n[l] |=> $stable(hold_flat[l*BYTE_W +: BYTE_W]));
  end
endmodule

bind lane_swap_buf lsb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_in     (bus_in),
  .cap_en_n   (cap_en_n),
  .copy_en_n  (copy_en_n),
  .drv_en_n   (drv_en_n),
  .test_n     (test_n),
  .data_out   (data_out),
  .lane_drive (lane_drive),
  .hold_flat  (hold_q)
);

// File: tb/sim_lane_swap_buf.sv
`timescale 1ns/1ps
module sim_lane_swap_buf;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_in;
  logic [3:0]  cap_en_n;
  logic [3:0]  copy_en_n;
  logic        copy_up;
  logic [2:0]  drv_en_n;
  logic        test_n;
  logic [31:0] data_out;
  logic [3:0]  lane_drive;

  int n_run = 0;
  int n_fail = 0;
  logic [3:0][7:0] mhold;

  always #2 clk = ~clk;

  lane_swap_buf u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_drv(input logic [2:0] oe, input logic t);
    if (!t) return 4'b0;
    return {~oe[2], ~oe[2], ~oe[1], ~oe[0]};
  endfunction

  function automatic logic [31:0] exp_out(input logic [3:0] ce, input logic up,
                                           input logic [2:0] oe, input logic t);
    logic [3:0][7:0] v;
    logic [3:0] dr;
    int lo[4] = '{0, 0, 0, 1};
    int hi[4] = '{1, 2, 3, 3};
    v  = mhold;
    dr = exp_drv(oe, t);
    for (int p = 3; p >= 0; p--) begin
      if (!ce[p]) begin
        if (up) v[hi[p]] = mhold[lo[p]];
        else    v[lo[p]] = mhold[hi[p]];
      end
    end
    for (int l = 0; l < 4; l++) if (!dr[l]) v[l] = 8'h00;
    return v;
  endfunction

  task automatic capture(input logic [31:0] d, input logic [3:0] mask_n);
    @(negedge clk);
    bus_in = d; cap_en_n = mask_n;
    @(posedge clk);
    for (int l = 0; l < 4; l++) if (!mask_n[l]) mhold[l] = d[l*8 +: 8];
    @(negedge clk);
    cap_en_n = 4'hF;
    #1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_in = '0; cap_en_n = 4'hF; copy_en_n = 4'hF;
    copy_up = 1'b0; drv_en_n = 3'b000; test_n = 1'b1; mhold = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 reset data", data_out, 32'h0);
    chk("R9 reset drive", {28'h0, lane_drive}, 32'hF);
    @(negedge clk); rst_n = 1'b1;

    // R3 / R1: every capture mask
    for (int m = 0; m < 16; m++) begin
      logic [31:0] d;
      d = 32'h9E3779B9 * (m + 1);
      capture(d, ~m[3:0]);
      chk("R3 capture mask", data_out, mhold);
    end
    capture(32'h0000AB00, 4'b1101);
    chk("R1 lane1 byte position", {24'h0, data_out[15:8]}, 32'hAB);

    capture(32'h44332211, 4'h0);
    chk("R1 lane map", data_out, 32'h44332211);

    // Full sweep of copy/direction/drive/test
    for (int c = 0; c < 16; c++)
      for (int u = 0; u < 2; u++)
        for (int o = 0; o < 8; o++)
          for (int t = 0; t < 2; t++) begin
            string rq;
            @(negedge clk);
            copy_en_n = c[3:0]; copy_up = u[0]; drv_en_n = o[2:0]; test_n = t[0];
            #1;
            if (t == 0)       rq = "R10";
            else if (o != 0)  rq = "R11";
            else if (c == 15) rq = "R4";
            else if (u == 1)  rq = "R5";
            else              rq = "R6";
            chk({rq, " data"}, data_out, exp_out(c[3:0], u[0], o[2:0], t[0]));
            chk("R9 drive", {28'h0, lane_drive}, {28'h0, exp_drv(o[2:0], t[0])});
          end

    // R7: up on pairs 0-3 and 1-3 -> lane3 gets lane0 byte
    @(negedge clk); test_n = 1; drv_en_n = 0; copy_up = 1; copy_en_n = 4'b0011; #1;
    chk("R7 up priority", {24'h0, data_out[31:24]}, 32'h11);
    // R7: down on 0-1 and 0-2 -> lane0 gets lane1 byte
    @(negedge clk); copy_up = 0; copy_en_n = 4'b1100; #1;
    chk("R7 down priority", {24'h0, data_out[7:0]}, 32'h22);
    // R8: down on 0-1 and 1-3 -> no chaining
    @(negedge clk); copy_en_n = 4'b0110; #1;
    chk("R8 no chaining", data_out, 32'h44334422);
    // R11: only lane 0 driven
    @(negedge clk); copy_en_n = 4'hF; drv_en_n = 3'b110; #1;
    chk("R11 undriven zero", data_out, 32'h00000011);

    // R2: asynchronous clear mid-cycle
    @(negedge clk); drv_en_n = 0; #1;
    rst_n = 1'b0; #0.5;
    chk("R2 async clear", data_out, 32'h0);
    mhold = '0;
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R2 stays clear", data_out, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule